// File: doc/BRIEF.md
# Mersenne Twister Random Word Generator

This block produces a stream of 32-bit pseudo-random words with the 19937-bit Mersenne Twister recurrence. Its 624-word state lives in an internal register array. After reset, the array is filled from a seed that is fixed at compile time. After a reseed strobe, it is filled from a seed presented on an input. Either way the fill writes one word per clock, and `busy` stays high until the fill is done.

Once `busy` is low, every clock edge with `enable` high twists one state word in place, tempers it and loads the result into the output register. The state is refreshed one word per draw, so the stream never stops for a bulk regeneration. A consumer may hold `enable` low for any number of cycles without losing or skipping a value.

Top module: `mt_prng`

## Requirements
- R1: A clock edge with `rst` high sets `busy` to 1 and `rnd` to 0, and selects the parameter `INIT_SEED` (default 0x31415926) as the seed for the next fill.
- R2: After the last edge with `rst` high, or after an edge that accepts a reseed, `busy` reads 1 for exactly 624 further rising edges and reads 0 after the 624th of them.
- R3: An edge with `rst` low and `reseed` high loads `seed` as the new seed and restarts the fill, so `busy` reads 1 after that edge.
- R4: A reseed that arrives while a fill is running abandons that fill and starts again from word 0 with the new seed, taking the full 624 edges of R2.
- R5: The fill sets word 0 to the seed and sets word k (1 to 623) to 1812433253 × (w[k-1] XOR (w[k-1] >> 30)) + k, modulo 2^32.
- R6: Each draw at position p takes bit 31 of w[p] and bits 30:0 of w[(p+1) mod 624], shifts that value right by one, XORs in 0x9908B0DF when its bit 0 is 1, and XORs in w[(p+397) mod 624]. The result is written back to w[p], and p advances modulo 624. p is 0 after every fill.
- R7: The value loaded into `rnd` is the twisted word y tempered as follows, in this order: y ^= y>>11, y ^= (y<<7) & 0x9D2C5680, y ^= (y<<15) & 0xEFC60000, y ^= y>>18.
- R8: `rnd` advances by exactly one sequence value on each edge with `enable` high, `busy` low and `reseed` low, and the new value is visible after that edge. Idle cycles between draws do not skip any value.
- R9: `enable` has no effect while `busy` is high. `rnd` keeps its value and the fill is not disturbed.
- R10: With seed 5489, the first draw after the fill yields `rnd` = 3499211612.
- R11: When `reseed` and `enable` are high on the same edge, the reseed is taken and `rnd` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Draw one word on this edge |
| reseed | input | 1 | Single-cycle strobe that restarts the fill from `seed` |
| seed | input | 32 | Seed taken on a reseed edge |
| rnd | output | 32 | Current tempered output word |
| busy | output | 1 | High while the state array is being filled |

## Verification
Every result here is registered, so a new `rnd` or `busy` value is due one rising edge after the stimulus that causes it. The only result that takes longer is the end of a fill, which comes 624 edges after the reset or reseed edge. The bench changes inputs on the falling edge, and its behavioural reference model advances on the following rising edge. It compares `busy` and `rnd` on the next falling edge, so each comparison lands one edge after the stimulus. The fill length is also measured on its own, as a count of edges during which `busy` stays high.

// File: rtl/mt_prng.sv
module mt_prng #(
  parameter logic [31:0] INIT_SEED = 32'h3141_5926
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        reseed,
  input  logic [31:0] seed,
  output logic [31:0] rnd,
  output logic        busy
);
  localparam int N  = 624;
  localparam int M  = 397;
  localparam int IW = $clog2(N);
  localparam logic [31:0] MATRIX = 32'h9908_B0DF;
  localparam logic [31:0] FILL_MUL = 32'd1812433253;

  logic [31:0]   st [N];
  logic [IW-1:0] idx;
  logic [31:0]   prev;
  logic [31:0]   seed_q;

  function automatic logic [31:0] temper(input logic [31:0] v);
    logic [31:0] y;
    y = v ^ (v >> 11);
    y = y ^ ((y << 7) & 32'h9D2C_5680);
    y = y ^ ((y << 15) & 32'hEFC6_0000);
    return y ^ (y >> 18);
  endfunction

  wire           idx_last = (idx == IW'(N - 1));
  wire [IW-1:0]  idx_nxt  = idx_last ? '0 : idx + IW'(1);
  wire [IW-1:0]  idx_far  = (idx >= IW'(N - M)) ? idx - IW'(N - M) : idx + IW'(M);

  wire [31:0] fill_val = (idx == '0) ? seed_q
                        : FILL_MUL * (prev ^ (prev >> 30)) + 32'(idx);

  wire [31:0] mix     = {st[idx][31], st[idx_nxt][30:0]};
  wire [31:0] twisted = st[idx_far] ^ (mix >> 1) ^ (mix[0] ? MATRIX : 32'h0);

  wire        draw  = !busy && enable;
  wire        st_we = !rst && !reseed && (busy || enable);
  wire [31:0] st_wd = busy ? fill_val : twisted;

  always_ff @(posedge clk)
    if (st_we) st[idx] <= st_wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b1;
      idx    <= '0;
      seed_q <= INIT_SEED;
      rnd    <= '0;
    end else if (reseed) begin
      busy   <= 1'b1;
      idx    <= '0;
      seed_q <= seed;
    end else if (busy) begin
      prev <= fill_val;
      idx  <= idx_nxt;
      if (idx_last) busy <= 1'b0;
    end else if (draw) begin
      rnd <= temper(twisted);
      idx <= idx_nxt;
    end
  end
endmodule

// File: rtl/mt_prng_chk.sv
module mt_prng_chk (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic        reseed,
  input logic [31:0] rnd,
  input logic        busy
);
  logic [10:0] fill_cnt;

  always_ff @(posedge clk)
    if (rst || reseed) fill_cnt <= '0;
    else if (busy && fill_cnt != 11'h7ff) fill_cnt <= fill_cnt + 11'd1;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (busy && rnd == 32'h0));

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fill_cnt < 11'd624));

  // R2
  fill_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (fill_cnt == 11'd624));

  // R3
  reseed_busy_chk: assert property (@(posedge clk) disable iff (rst)
    reseed |=> busy);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reseed));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable || busy || reseed) |=> $stable(rnd));
endmodule

bind mt_prng mt_prng_chk i_chk (
  .clk(clk), .rst(rst), .enable(enable), .reseed(reseed), .rnd(rnd), .busy(busy)
);

// File: tb/test_mt_prng.sv
module test_mt_prng;
  localparam logic [31:0] SEED0 = 32'h3141_5926;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic reseed = 1'b0;
  logic [31:0] seed = '0;
  logic [31:0] rnd;
  logic busy;

  int checks = 0;
  int fails = 0;

  mt_prng #(.INIT_SEED(SEED0)) i_mt_prng (
    .clk(clk), .rst(rst), .enable(enable), .reseed(reseed),
    .seed(seed), .rnd(rnd), .busy(busy)
  );

  always #4 clk = ~clk;

  logic [31:0] mdl [624];
  int          mdl_pos;
  int          left;
  logic [31:0] exp_rnd;

  task automatic mdl_seed(input logic [31:0] s);
    mdl[0] = s;
    for (int k = 1; k < 624; k++)
      mdl[k] = 32'd1812433253 * (mdl[k-1] ^ (mdl[k-1] >> 30)) + 32'(k);
    mdl_pos = 624;
  endtask

  task automatic mdl_next(output logic [31:0] r);
    logic [31:0] y;
    if (mdl_pos >= 624) begin
      for (int k = 0; k < 624; k++) begin
        y = (mdl[k] & 32'h8000_0000) | (mdl[(k + 1) % 624] & 32'h7fff_ffff);
        mdl[k] = mdl[(k + 397) % 624] ^ (y >> 1) ^ ((y & 1) != 0 ? 32'h9908_b0df : 32'h0);
      end
      mdl_pos = 0;
    end
    y = mdl[mdl_pos];
    mdl_pos++;
    y ^= y >> 11;
    y ^= (y << 7) & 32'h9d2c_5680;
    y ^= (y << 15) & 32'hefc6_0000;
    y ^= y >> 18;
    r = y;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(busy == (left != 0), tag, 32'(busy), 32'(left != 0));
    chk(rnd == exp_rnd, tag, rnd, exp_rnd);
  endtask

  task automatic step(input logic en, input logic rs, input logic [31:0] sd, input string tag);
    logic [31:0] r;
    enable = en; reseed = rs; seed = sd;
    @(posedge clk);
    if (rst) begin
      left = 624; mdl_seed(SEED0); exp_rnd = 32'h0;
    end else if (rs) begin
      left = 624; mdl_seed(sd);
    end else if (left > 0) begin
      left--;
    end else if (en) begin
      mdl_next(r); exp_rnd = r;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_fill(input string tag);
    int n = 0;
    while (busy && n < 2000) begin
      step(1'b1, 1'b0, 32'h0, "R9");
      n++;
    end
    chk(n == 624, tag, 32'(n), 32'd624);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 32'h0, "R1");
    rst = 1'b0;
    run_fill("R2");
    for (int i = 0; i < 1500; i++)
      step((i % 5 != 0) && (i % 7 != 0), 1'b0, 32'h0, "R8");
    step(1'b1, 1'b1, 32'hfedc_ba98, "R11");
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 32'h0, "R3");
    step(1'b0, 1'b1, 32'd5489, "R4");
    run_fill("R4");
    step(1'b1, 1'b0, 32'h0, "R10");
    chk(rnd == 32'd3499211612, "R10", rnd, 32'd3499211612);
    for (int i = 0; i < 1400; i++)
      step(i % 3 != 1, 1'b0, 32'h0, "R6");
    step(1'b0, 1'b1, 32'hfedc_ba98, "R3");
    run_fill("R5");
    for (int i = 0; i < 700; i++)
      step((i % 5 != 1) && (i % 7 != 1), 1'b0, 32'h0, "R7");
    finish_run();
  end
endmodule